// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Loader

This block takes a serial bit stream on a shared serial clock and shifts it into a configuration register, one bit per edge, but only while its active-low chain enable input is asserted. Once the required number of bits has arrived, the block marks itself programmed, stops listening to the stream, and from then on copies its enable input to its active-low enable output. That output drives the enable input of the next device in a cascade.

Because each device hands the enable on only after its own load is finished, a single stream on a single clock can program a whole chain in order. The first device's enable is driven by the user. The output enable going low also means the device is ready for normal traffic. A queue-select strobe from the read side is passed through only after that point.

Top module: `cfg_chain_loader`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `cfg_word` is all zeros, `prog_done` is 0 and `sen_out_n` is 1.
- R2: A rising `sclk` edge moves `sdata` into the register only while `sen_in_n` is 0. With `sen_in_n` at 1, `cfg_word` keeps its value.
- R3: The stream is loaded first bit first. Each accepted bit enters at bit 0 while the earlier bits move up by one. After all CFG_BITS (default 64) bits, the first bit sent is at bit CFG_BITS-1.
- R4: `prog_done` goes to 1 on the edge that accepts bit number CFG_BITS and not on any earlier edge.
- R5: While `prog_done` is 0, `sen_out_n` stays 1 whatever `sen_in_n` does.
- R6: Once `prog_done` is 1, `sen_out_n` equals `sen_in_n` in the same cycle. It goes low with the input and back high when the input is raised.
- R7: After `prog_done` is 1, further `sclk` edges change neither `cfg_word` nor `prog_done`, for any `sdata` or `sen_in_n`.
- R8: `sel_accept` is 1 only when `sel_req` is 1, `prog_done` is 1 and `sen_out_n` is 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock, shared by all devices in the chain |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata | input | 1 | Serial configuration data |
| sen_in_n | input | 1 | Chain enable input, active low |
| sel_req | input | 1 | Read-side queue-select strobe to be gated |
| sen_out_n | output | 1 | Chain enable output, active low |
| prog_done | output | 1 | Configuration load complete |
| sel_accept | output | 1 | Queue-select strobe after gating |
| cfg_word | output | CFG_BITS | Parallel configuration register |

## Verification
The shift register is visible as `cfg_word`, so a wrongly accepted bit, a dropped bit or a reversed order shows up at the port on the very edge where it happens. A bit counter that is off by one shows up as `prog_done` rising one edge early or late. In a chain, that also moves the hand-off of `sen_out_n` to the next device. A wrong pass-through or a wrong gate appears in the same cycle, because both outputs are combinational functions of `prog_done` and the inputs.

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader #(
  parameter int CFG_BITS = 64,
  localparam int CNT_W = $clog2(CFG_BITS + 1)
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                sdata,
  input  logic                sen_in_n,
  input  logic                sel_req,
  output logic                sen_out_n,
  output logic                prog_done,
  output logic                sel_accept,
  output logic [CFG_BITS-1:0] cfg_word
);

  logic [CNT_W-1:0] bit_cnt;
  logic             take_bit;

  assign prog_done  = (bit_cnt == CNT_W'(CFG_BITS));
  assign take_bit   = !prog_done && !sen_in_n;
  assign sen_out_n  = prog_done ? sen_in_n : 1'b1;
  assign sel_accept = sel_req && prog_done && !sen_out_n;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      cfg_word <= '0;
    end else if (take_bit) begin
      bit_cnt  <= bit_cnt + CNT_W'(1);
      cfg_word <= {cfg_word[CFG_BITS-2:0], sdata};
    end
  end

  a_r2_hold_when_idle: assert property (@(posedge sclk) disable iff (!rst_n)
    sen_in_n |=> $stable(cfg_word));

  a_r3_shift_in: assert property (@(posedge sclk) disable iff (!rst_n)
    (!prog_done && !sen_in_n) |=> cfg_word[CFG_BITS-1:1] == $past(cfg_word[CFG_BITS-2:0]));

  a_r4_count_step: assert property (@(posedge sclk) disable iff (!rst_n)
    (!prog_done && !sen_in_n) |=> bit_cnt == $past(bit_cnt) + CNT_W'(1));

  a_r5_blocked: assert property (@(posedge sclk) disable iff (!rst_n)
    !prog_done |-> sen_out_n);

  a_r7_frozen: assert property (@(posedge sclk) disable iff (!rst_n)
    prog_done |=> prog_done && $stable(cfg_word));

  a_r8_gate: assert property (@(posedge sclk) disable iff (!rst_n)
    sel_accept |-> (prog_done && !sen_out_n && sel_req));

endmodule

// File: tb/cfg_chain_loader_test.sv
module cfg_chain_loader_test;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic sen_in_n = 1'b1;
  logic sel_req = 1'b0;
  logic sen_out_n, prog_done, sel_accept;
  logic [N-1:0] cfg_word;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model;
  int loaded;

  always #4 clk = ~clk;

  cfg_chain_loader #(.CFG_BITS(N)) uut (
    .sclk(clk), .rst_n(rst_n), .sdata(sdata), .sen_in_n(sen_in_n),
    .sel_req(sel_req), .sen_out_n(sen_out_n), .prog_done(prog_done),
    .sel_accept(sel_accept), .cfg_word(cfg_word)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sen_in_n = 1'b1; sdata = 1'b0; sel_req = 1'b0;
    #1;
    chk("R1 cfg_word in reset", cfg_word, '0);
    chk("R1 done in reset", N'(prog_done), '0);
    chk("R1 sen_out_n in reset", N'(sen_out_n), N'(1));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 cfg_word after reset", cfg_word, '0);
    model = '0; loaded = 0;
  endtask

  task automatic step(input logic en_n, input logic d);
    @(negedge clk);
    sen_in_n = en_n; sdata = d;
    #1;
    if (loaded < N)
      chk("R5 sen_out_n blocked", N'(sen_out_n), N'(1));
    else
      chk("R6 sen_out_n follows", N'(sen_out_n), N'(en_n));
    @(posedge clk); #2;
    if (!en_n && loaded < N) begin
      model = {model[N-2:0], d};
      loaded++;
    end
    chk(en_n ? "R2 idle edge keeps word" : (loaded < N ? "R3 shift" : "R7 frozen"), cfg_word, model);
    chk(loaded == N ? "R4 done set" : "R4 done not yet", N'(prog_done), N'(loaded == N));
  endtask

  function automatic logic pat_bit(input int p, input int i);
    case (p)
      0: return 1'b1;
      1: return 1'(i % 2);
      2: return 1'(((i * 37 + 11) % 7) < 3);
      default: return 1'(i / 8 % 2);
    endcase
  endfunction

  initial begin
    for (int p = 0; p < 4; p++) begin
      logic [N-1:0] want;
      do_reset();
      sel_req = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (i % (p + 3) == 1) step(1'b1, ~pat_bit(p, i));
        step(1'b0, pat_bit(p, i));
        chk("R8 gate closed before done", N'(sel_accept), N'(loaded == N));
      end
      want = '0;
      for (int i = 0; i < N; i++) want[N-1-i] = pat_bit(p, i);
      chk("R3 full word order", cfg_word, want);
      for (int k = 0; k < 6; k++) step(1'(k % 2), 1'(k % 3 == 0));
      chk("R7 word after extra clocks", cfg_word, want);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        sel_req = 1'(c % 2); sen_in_n = 1'(c / 2);
        #1;
        chk("R6 pass-through", N'(sen_out_n), N'(c / 2));
        chk("R8 gate after done", N'(sel_accept), N'((c % 2 == 1) && (c / 2 == 0)));
      end
      sel_req = 1'b0;
    end
    do_reset();
    sel_req = 1'b1;
    for (int i = 0; i < N - 1; i++) step(1'b0, 1'b1);
    chk("R4 one short not done", N'(prog_done), '0);
    chk("R8 one short gate", N'(sel_accept), '0);
    step(1'b0, 1'b0);
    chk("R4 last bit done", N'(prog_done), N'(1));
    chk("R3 last bit at lsb", N'(cfg_word[0]), '0);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 reset after done", N'(prog_done), '0);
    chk("R1 sen_out_n after done reset", N'(sen_out_n), N'(1));
    rst_n = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule